// File: doc/BRIEF.md
# Two-Step Flash Conversion Sequencer

This block is the digital control of an 8-bit two-step (semiflash) converter. The converter has a single bank of 16 comparators, and the bank is reused in time. A start request runs the block through four phases in fixed order. First it auto-zeros the comparators while the input is acquired. Next it makes a coarse comparison against the main ladder taps. Then it makes a fine comparison of the residue against the sub-ladder taps. Last it commits the result.

Each of the three timed phases lasts a programmable number of clock cycles, so the total conversion time can be trimmed without changing the logic. On the last cycle of the coarse phase, the block captures the comparator thermometer code and holds it. That held code drives the unit-element DAC directly, with no decoding. On the last cycle of the fine phase, it captures the second code. Each code is turned into a count of asserted comparators. The two counts form the upper and lower nibbles, and both nibbles are written to the output register in one update together with an active-low overflow flag.

The comparator outputs arrive as a digital vector. The ladder, the capacitors, the half-LSB input offset and the DAC are all analog and lie outside this block.

Top module: `semiflash_seq`

## Requirements
- R1: While reset is high, and in the cycle after it, every phase strobe, `done` and `dac_therm` are zero, `code` is 0x00 and `ovf_n` is 1, whatever phase was in progress when reset arrived.
- R2: A conversion drives the phase strobes in the order `sw_zero`, `sw_coarse`, `sw_fine`, `latch_strobe`. At most one strobe is high in any cycle, and `latch_strobe` is high for exactly one cycle.
- R3: The zero, coarse and fine phases last `len_zero`, `len_coarse` and `len_fine` cycles, with a length of 0 treated as 1. The new result appears len_zero+len_coarse+len_fine+1 rising edges after the edge that accepts `start`.
- R4: On the last coarse cycle, `cmp_in` is captured onto `dac_therm`. That value holds unchanged through the whole fine phase and until the next coarse capture.
- R5: The upper nibble of `code` (bits 7:4) is the number of `cmp_in` bits that were high in the last coarse cycle, provided that number is below 16.
- R6: The lower nibble of `code` (bits 3:0) is the number of `cmp_in` bits that were high in the last fine cycle.
- R7: Each nibble comes from the count of set bits, not from the highest set position. A thermometer code with one bubble (one bit cleared below the top and the next bit above set) yields the same value as its clean form.
- R8: `code` and `ovf_n` change only at the commit edge, both at once. `done` is high for exactly the one cycle that follows that edge.
- R9: With sum = 16*coarse_count + fine_count, a sum above 255 sets `code` to 0xFF and drives `ovf_n` to 0. Otherwise `ovf_n` is 1 and `code` is the sum. A sum of exactly 255 (input at the top reference) gives 0xFF with `ovf_n`=1.
- R10: A `start` that arrives while a conversion is in progress is ignored. It neither restarts the sequence nor queues a second one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Conversion request, accepted only when idle |
| len_zero | input | CNT_W | Auto-zero/sample phase length in cycles (0 means 1) |
| len_coarse | input | CNT_W | Coarse phase length in cycles (0 means 1) |
| len_fine | input | CNT_W | Fine phase length in cycles (0 means 1) |
| cmp_in | input | NCMP | Comparator bank outputs, thermometer code |
| sw_zero | output | 1 | Auto-zero and input-sample switches closed |
| sw_coarse | output | 1 | Coarse-tap switch closed |
| sw_fine | output | 1 | Fine-tap switch closed |
| latch_strobe | output | 1 | Commit cycle; the hold circuit returns to acquire |
| dac_therm | output | NCMP | Held coarse code that drives the unit-element DAC |
| code | output | 2*log2(NCMP) | Converted result |
| ovf_n | output | 1 | Overflow flag, low when the input exceeds the reference |
| done | output | 1 | One-cycle pulse when a new result is on `code` |

## Verification
The assertions assume that `start` only matters in the idle phase and that reset is held for at least one edge before use. They also assume that `cmp_in` is sampled only on the last cycle of a compare phase, so they make no claim about it at other times. The bench obeys these assumptions by driving `cmp_in` from an integer model of the ladder and DAC. That model reads only the phase strobes and `dac_therm`, and returns zero outside the two compare phases. The model produces true thermometer codes with at most the single deliberate bubble, and it keeps the coarse count below 16 except in the overflow vectors, so the fine count can only reach 16 when the coarse count already has.

// File: rtl/semiflash_pkg.sv
package semiflash_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ZERO,
    PH_COARSE,
    PH_FINE,
    PH_COMMIT
  } phase_e;

  function automatic phase_e phase_after(input phase_e p);
    case (p)
      PH_ZERO:   return PH_COARSE;
      PH_COARSE: return PH_FINE;
      PH_FINE:   return PH_COMMIT;
      default:   return PH_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/sf_phase_ctrl.sv
module sf_phase_ctrl
  import semiflash_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] len_zero,
  input  logic [CNT_W-1:0] len_coarse,
  input  logic [CNT_W-1:0] len_fine,
  output phase_e           phase,
  output logic             last
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] len_sel;
  logic [CNT_W-1:0] span;
  logic             timed;

  always_comb begin
    case (phase)
      PH_ZERO:   len_sel = len_zero;
      PH_COARSE: len_sel = len_coarse;
      PH_FINE:   len_sel = len_fine;
      default:   len_sel = '0;
    endcase
    span  = (len_sel == '0) ? CNT_W'(1) : len_sel;
    timed = (phase == PH_ZERO) || (phase == PH_COARSE) || (phase == PH_FINE);
    last  = (phase == PH_COMMIT) || (timed && (cnt == span - CNT_W'(1)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else begin
      case (phase)
        PH_IDLE: begin
          cnt <= '0;
          if (start) phase <= PH_ZERO;
        end
        PH_COMMIT: begin
          cnt   <= '0;
          phase <= PH_IDLE;
        end
        default: begin
          if (last) begin
            cnt   <= '0;
            phase <= phase_after(phase);
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
      endcase
    end
  end

  // R2: each phase is entered only from its predecessor
  a_r2_coarse_after_zero: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_COARSE && $past(phase) != PH_COARSE) |-> $past(phase) == PH_ZERO);
  a_r2_fine_after_coarse: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_FINE && $past(phase) != PH_FINE) |-> $past(phase) == PH_COARSE);
  a_r2_commit_after_fine: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_COMMIT) |-> $past(phase) == PH_FINE);

  // R3: a timed phase advances its cycle count by one until its last cycle
  a_r3_count_steps: assert property (@(posedge clk) disable iff (rst)
    (timed && phase == $past(phase)) |-> cnt == $past(cnt) + CNT_W'(1));

  // R10: a new sequence begins only from idle
  a_r10_start_from_idle: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_ZERO && $past(phase) != PH_ZERO) |-> $past(phase) == PH_IDLE);

endmodule

// File: rtl/sf_therm_count.sv
module sf_therm_count #(
  parameter int N  = 16,
  parameter int CW = $clog2(N + 1)
) (
  input  logic [N-1:0]  code,
  output logic [CW-1:0] count
);

  // Population count: a single bubble does not move the result (R7)
  always_comb begin
    count = '0;
    for (int i = 0; i < N; i++) begin
      count = count + CW'(code[i]);
    end
  end

endmodule

// File: rtl/sf_result.sv
module sf_result #(
  parameter int NIB = 4,
  localparam int CW = NIB + 1,
  localparam int DW = 2 * NIB,
  localparam int SW = DW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] coarse_cnt,
  input  logic [CW-1:0] fine_cnt,
  output logic [DW-1:0] code,
  output logic          ovf_n,
  output logic          done
);

  localparam logic [SW-1:0] MAX_CODE = SW'((1 << DW) - 1);

  logic [SW-1:0] sum;
  logic          over;

  always_comb begin
    sum  = (SW'(coarse_cnt) << NIB) + SW'(fine_cnt);
    over = sum > MAX_CODE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code  <= '0;
      ovf_n <= 1'b1;
      done  <= 1'b0;
    end else begin
      done <= load;
      if (load) begin
        code  <= over ? '1 : sum[DW-1:0];
        ovf_n <= ~over;
      end
    end
  end

  // R9: an overflowed result is saturated to all ones
  a_r9_ovf_saturates: assert property (@(posedge clk) disable iff (rst)
    !ovf_n |-> code == '1);

  // R8: the result only moves on the commit edge
  a_r8_hold_between: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(code) && $stable(ovf_n)));

  // R8: completion is a single-cycle pulse
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

endmodule

// File: rtl/semiflash_seq.sv
module semiflash_seq
  import semiflash_pkg::*;
#(
  parameter int NCMP  = 16,
  parameter int CNT_W = 8,
  localparam int NIB = $clog2(NCMP),
  localparam int CW  = NIB + 1,
  localparam int DW  = 2 * NIB
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] len_zero,
  input  logic [CNT_W-1:0] len_coarse,
  input  logic [CNT_W-1:0] len_fine,
  input  logic [NCMP-1:0]  cmp_in,
  output logic             sw_zero,
  output logic             sw_coarse,
  output logic             sw_fine,
  output logic             latch_strobe,
  output logic [NCMP-1:0]  dac_therm,
  output logic [DW-1:0]    code,
  output logic             ovf_n,
  output logic             done
);

  phase_e          phase;
  logic            last;
  logic [NCMP-1:0] coarse_q;
  logic [NCMP-1:0] fine_q;
  logic [NCMP-1:0] codes  [2];
  logic [CW-1:0]   counts [2];

  sf_phase_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .len_zero   (len_zero),
    .len_coarse (len_coarse),
    .len_fine   (len_fine),
    .phase      (phase),
    .last       (last)
  );

  // Strobes decode the registered phase
  assign sw_zero      = (phase == PH_ZERO);
  assign sw_coarse    = (phase == PH_COARSE);
  assign sw_fine      = (phase == PH_FINE);
  assign latch_strobe = (phase == PH_COMMIT);

  // One comparator bank, sampled once per compare phase
  always_ff @(posedge clk) begin
    if (rst) begin
      coarse_q <= '0;
      fine_q   <= '0;
    end else begin
      if (sw_coarse && last) coarse_q <= cmp_in;
      if (sw_fine && last)   fine_q   <= cmp_in;
    end
  end

  assign dac_therm = coarse_q;
  assign codes[0]  = coarse_q;
  assign codes[1]  = fine_q;

  for (genvar g = 0; g < 2; g++) begin : g_count
    sf_therm_count #(.N(NCMP), .CW(CW)) u_cnt (
      .code  (codes[g]),
      .count (counts[g])
    );
  end

  sf_result #(.NIB(NIB)) u_res (
    .clk        (clk),
    .rst        (rst),
    .load       (latch_strobe),
    .coarse_cnt (counts[0]),
    .fine_cnt   (counts[1]),
    .code       (code),
    .ovf_n      (ovf_n),
    .done       (done)
  );

  // R2: phase strobes never overlap
  a_r2_onehot_strobes: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sw_zero, sw_coarse, sw_fine, latch_strobe}));

  // R4: the DAC drive is frozen for the whole fine phase
  a_r4_dac_frozen: assert property (@(posedge clk) disable iff (rst)
    (sw_fine && $past(sw_fine)) |-> $stable(dac_therm));

  // R4: the DAC drive changes only when leaving the coarse phase
  a_r4_dac_moves_at_capture: assert property (@(posedge clk) disable iff (rst)
    !$stable(dac_therm) |-> $past(sw_coarse));

endmodule

// File: tb/sim_semiflash_seq.sv
module sim_semiflash_seq;

  localparam int NV = 10;
  // input in half-LSB units, expected code and flag, phase lengths, bubble
  localparam int         V2  [NV] = '{0, 1, 30, 31, 200, 255, 510, 511, 600, 400};
  localparam logic [7:0] EXC [NV] = '{8'h00, 8'h01, 8'h0F, 8'h10, 8'h64,
                                      8'h80, 8'hFF, 8'hFF, 8'hFF, 8'hC8};
  localparam logic       EXO [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1,
                                      1'b1, 1'b1, 1'b0, 1'b0, 1'b1};
  localparam int         LZ  [NV] = '{1, 2, 0, 3, 1, 5, 1, 2, 1, 2};
  localparam int         LC  [NV] = '{1, 3, 0, 1, 2, 5, 1, 2, 1, 1};
  localparam int         LF  [NV] = '{1, 2, 0, 4, 1, 5, 1, 2, 1, 3};
  localparam logic       BUB [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1,
                                      1'b0, 1'b0, 1'b0, 1'b0, 1'b1};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  len_zero = 8'd1, len_coarse = 8'd1, len_fine = 8'd1;
  logic [15:0] cmp_in;
  logic        sw_zero, sw_coarse, sw_fine, latch_strobe;
  logic [15:0] dac_therm;
  logic [7:0]  code;
  logic        ovf_n, done;

  int   v2 = 0;
  logic bub = 1'b0;
  int   checks = 0;
  int   fails = 0;

  always #5 clk = ~clk;

  semiflash_seq u0 (
    .clk(clk), .rst(rst), .start(start),
    .len_zero(len_zero), .len_coarse(len_coarse), .len_fine(len_fine),
    .cmp_in(cmp_in), .sw_zero(sw_zero), .sw_coarse(sw_coarse),
    .sw_fine(sw_fine), .latch_strobe(latch_strobe), .dac_therm(dac_therm),
    .code(code), .ovf_n(ovf_n), .done(done)
  );

  // Integer model of ladder, half-LSB offset and unit-element DAC
  function automatic logic [15:0] model_cmp(input logic co, input logic fi,
                                            input logic [15:0] dac, input int v,
                                            input logic b);
    int n;
    int r;
    logic [15:0] t;
    if (co) n = (v + 1) / 32;
    else if (fi) begin
      r = v + 1 - 32 * $countones(dac);
      n = (r < 0) ? 0 : r / 2;
    end else return '0;
    if (n > 16) n = 16;
    t = (n == 16) ? 16'hFFFF : 16'((32'd1 << n) - 1);
    if (b && n >= 2 && n < 16) begin
      t[n-2] = 1'b0;
      t[n]   = 1'b1;
    end
    return t;
  endfunction

  always_comb cmp_in = model_cmp(sw_coarse, sw_fine, dac_therm, v2, bub);

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int eff(input int n);
    return (n == 0) ? 1 : n;
  endfunction

  // Run one conversion; optionally pulse start again in the middle
  task automatic convert(input int v, input int lz, input int lc, input int lf,
                         input logic b, input logic poke, input logic [7:0] ec,
                         input logic eo);
    int cyc = 0;
    int nz = 0, nc = 0, nf = 0, nl = 0;
    int dac_bad = 0, moved = 0;
    int expc;
    logic [7:0] prev_code;
    logic prev_ovf;
    v2 = v; bub = b;
    len_zero = 8'(lz); len_coarse = 8'(lc); len_fine = 8'(lf);
    expc = (v + 1) / 32;
    if (expc > 16) expc = 16;
    @(negedge clk);
    prev_code = code; prev_ovf = ovf_n;
    start = 1'b1;
    @(posedge clk);
    forever begin
      @(negedge clk);
      start = (poke && cyc == 2);
      nz += int'(sw_zero); nc += int'(sw_coarse);
      nf += int'(sw_fine); nl += int'(latch_strobe);
      if (sw_fine && $countones(dac_therm) != expc) dac_bad++;
      if (done) break;
      if (code != prev_code || ovf_n != prev_ovf) moved++;
      if (cyc > 300) break;
      @(posedge clk);
      cyc++;
    end
    start = 1'b0;
    check(cyc == eff(lz) + eff(lc) + eff(lf) + 1, "R3 latency", cyc,
          eff(lz) + eff(lc) + eff(lf) + 1);
    check(nz == eff(lz) && nc == eff(lc) && nf == eff(lf), "R3 phase lengths",
          nz * 10000 + nc * 100 + nf, eff(lz) * 10000 + eff(lc) * 100 + eff(lf));
    check(nl == 1, "R2 single commit strobe", nl, 1);
    check(dac_bad == 0, "R4 dac held in fine phase", dac_bad, 0);
    check(moved == 0, "R8 result static before commit", moved, 0);
    check(code[7:4] == ec[7:4], "R5 upper nibble", code[7:4], ec[7:4]);
    check(code == ec, b ? "R7 bubble code" : "R6 R9 full code", code, ec);
    check(ovf_n == eo, "R9 overflow flag", ovf_n, eo);
    @(negedge clk);
    check(done == 1'b0, "R8 done one cycle", done, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R3 watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R1: reset values
    repeat (3) @(negedge clk);
    check({sw_zero, sw_coarse, sw_fine, latch_strobe, done} == 5'b0,
          "R1 strobes in reset", {sw_zero, sw_coarse, sw_fine, latch_strobe, done}, 0);
    check(code == 8'h00 && ovf_n == 1'b1, "R1 result in reset", {code, ovf_n}, 1);
    check(dac_therm == 16'h0, "R1 dac in reset", dac_therm, 0);
    rst = 1'b0;
    @(negedge clk);
    check(sw_zero == 1'b0 && done == 1'b0, "R1 idle after reset", {sw_zero, done}, 0);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      convert(V2[i], LZ[i], LC[i], LF[i], BUB[i], 1'b0, EXC[i], EXO[i]);
    end

    // R10: start during a conversion
    convert(255, 2, 2, 2, 1'b0, 1'b1, 8'h80, 1'b1);
    begin
      int seen = 0;
      for (int k = 0; k < 10; k++) begin
        @(negedge clk);
        seen += int'(sw_zero) + int'(done);
      end
      check(seen == 0, "R10 no second conversion", seen, 0);
    end

    // R1: reset in the middle of a conversion
    v2 = 400; bub = 1'b0;
    len_zero = 8'd2; len_coarse = 8'd2; len_fine = 8'd2;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check({sw_zero, sw_coarse, sw_fine, latch_strobe, done} == 5'b0,
          "R1 strobes after mid reset",
          {sw_zero, sw_coarse, sw_fine, latch_strobe, done}, 0);
    check(code == 8'h00 && ovf_n == 1'b1 && dac_therm == 16'h0,
          "R1 state after mid reset", code, 0);
    rst = 1'b0;
    @(negedge clk);
    convert(31, 1, 1, 1, 1'b0, 1'b0, 8'h10, 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule